// File: doc/BRIEF.md
# Reference-Counted Heap Allocator Engine

This engine owns a word-addressed heap kept in a local RAM. It accepts one command at a time over a valid/ready port: it can set up an empty heap, hand out a block, drop a reference to a block, add a reference to a block, or read back any heap word. Every block begins with a one-word header. The header packs a free flag, a handle flag, a five-bit reference count and the block length in words, where the length counts the header itself. The heap stores no pointers. Blocks are found only by stepping from header to header, starting at word 0.

Allocation is first-fit. While walking, the engine joins runs of adjacent free blocks in place. It writes the joined header back when the run still cannot satisfy the request. When the chosen block is larger than needed, the engine splits off the tail as a new free block. A block returns to the free state only when its last reference is dropped. A caller that marks an allocation as a handle gets the handle number stored in the first data word. Data addresses always point one word past a header, so address 0 can never be a valid result and serves as the null value.

Top module: `heap_alloc_engine`

## Requirements
- R1: Header layout: bit 15 is free, bit 14 is handle, bits 13:9 are the reference count, and bits 8:0 are the block length in words including the header. Opcode 0 (setup) writes one free header covering the whole heap at word 0 (0x8100 for 256 words) and returns that header in rsp_data.
- R2: Opcode 1 (allocate, cmd_arg = data words n) picks the first block in address order that can hold n+1 words. It writes the header as used with count 1 and length n+1, returns header address + 1 in rsp_addr, returns the header in rsp_data, and clears rsp_err. An exact fit writes no further header.
- R3: When the chosen block is longer than n+1, a free header with the leftover length is written directly after the new block.
- R4: An allocate with n = 0 or n > 256 words (more than 512 bytes) returns rsp_err = 1, rsp_addr = 0 and rsp_data = 0, and leaves the heap unchanged.
- R5: When no block fits after walking the whole heap, allocate returns rsp_err = 1 and rsp_addr = 0 (null).
- R6: Opcode 2 (drop reference, cmd_arg = data address) lowers the count by one and returns the new header. Only the step to zero sets the free flag and clears the handle flag. The length is kept.
- R7: Opcode 3 (add reference) raises the count by one, which adds 0x0200 to the header. At count 31 it returns rsp_err = 1 and the unchanged header.
- R8: Allocate with cmd_handle = 1 sets header bit 14 and writes cmd_handle_id to the word right after the header.
- R9: During an allocate walk, a free block followed by free blocks is joined with them into one block before the fit test. Allocation can therefore succeed across former block borders.
- R10: Drop or add reference with address 0, an address at or past the heap end, or an address whose header is free, returns rsp_err = 1 and changes no heap word.
- R11: Opcode 4 (read) returns the heap word at cmd_arg. An address at or past the heap end returns rsp_err = 1 and data 0.
- R12: cmd_ready is high only while idle. Each accepted command produces exactly one one-cycle rsp_valid pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Engine idle, command taken when valid |
| cmd_op | input | 3 | 0 setup, 1 allocate, 2 drop ref, 3 add ref, 4 read |
| cmd_arg | input | 16 | Word count (allocate) or address |
| cmd_handle | input | 1 | Mark the allocation as a handle block |
| cmd_handle_id | input | 16 | Handle number stored after the header |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | Command rejected or failed |
| rsp_addr | output | 16 | Allocated data address, 0 for null |
| rsp_data | output | 16 | Header written or word read |

## Verification
Heap state is visible only through the headers. A wrong split length, a missed join or a count step that skips shows up as a wrong address on a later allocate, or as a wrong word on a read of the affected header. A fault of this kind therefore surfaces within one or two commands of the step that caused it. The stimulus chains allocations, drops, joins, exact fits and count saturation, so that each header is read back right after it changes.

// File: rtl/heap_pkg.sv
`timescale 1ns/1ps
package heap_pkg;

  typedef enum logic [2:0] {
    OP_INIT   = 3'd0,
    OP_ALLOC  = 3'd1,
    OP_FREE   = 3'd2,
    OP_ADDREF = 3'd3,
    OP_PEEK   = 3'd4
  } heap_op_e;

  // Packed block header; field order fixes the bit positions.
  typedef struct packed {
    logic       is_free;
    logic       has_handle;
    logic [4:0] refs;
    logic [8:0] words;
  } blk_hdr_t;

  localparam logic [4:0] REF_LIMIT = 5'd31;

endpackage

// File: rtl/heap_ram.sv
`timescale 1ns/1ps
module heap_ram #(
  parameter int DEPTH = 256,
  parameter int DW    = 16,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] store [DEPTH];

  // Single port, read-first, one cycle read latency.
  always_ff @(posedge clk) begin
    if (we) store[addr] <= wdata;
    rdata <= store[addr];
  end

endmodule

// File: rtl/heap_cmd_check.sv
`timescale 1ns/1ps
module heap_cmd_check
  import heap_pkg::*;
#(
  parameter int HEAP_WORDS    = 256,
  parameter int MAX_REQ_WORDS = 256
) (
  input  logic [2:0]  op,
  input  logic [15:0] arg,
  output logic        reject,
  output logic [15:0] need
);

  localparam logic [15:0] HEAP_END = 16'(HEAP_WORDS);
  localparam logic [15:0] REQ_MAX  = 16'(MAX_REQ_WORDS);

  always_comb begin
    need = arg + 16'd1;
    unique case (op)
      OP_INIT:              reject = 1'b0;
      OP_ALLOC:             reject = (arg == 16'd0) || (arg > REQ_MAX);
      OP_FREE, OP_ADDREF:   reject = (arg == 16'd0) || (arg >= HEAP_END);
      OP_PEEK:              reject = (arg >= HEAP_END);
      default:              reject = 1'b1;
    endcase
  end

endmodule

// File: rtl/heap_ref_update.sv
`timescale 1ns/1ps
module heap_ref_update
  import heap_pkg::*;
(
  input  blk_hdr_t cur,
  input  logic     raise,
  output blk_hdr_t nxt,
  output logic     bad
);

  always_comb begin
    nxt = cur;
    bad = cur.is_free || (cur.refs == 5'd0) || (raise && (cur.refs == REF_LIMIT));
    if (raise) begin
      nxt.refs = cur.refs + 5'd1;
    end else if (cur.refs == 5'd1) begin
      nxt.refs       = 5'd0;
      nxt.is_free    = 1'b1;
      nxt.has_handle = 1'b0;
    end else begin
      nxt.refs = cur.refs - 5'd1;
    end
  end

endmodule

// File: rtl/heap_alloc_engine.sv
`timescale 1ns/1ps
module heap_alloc_engine
  import heap_pkg::*;
#(
  parameter int HEAP_WORDS    = 256,
  parameter int MAX_REQ_WORDS = 256
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        cmd_valid,
  output logic        cmd_ready,
  input  logic [2:0]  cmd_op,
  input  logic [15:0] cmd_arg,
  input  logic        cmd_handle,
  input  logic [15:0] cmd_handle_id,
  output logic        rsp_valid,
  output logic        rsp_err,
  output logic [15:0] rsp_addr,
  output logic [15:0] rsp_data
);

  localparam int          AW       = (HEAP_WORDS > 1) ? $clog2(HEAP_WORDS) : 1;
  localparam logic [15:0] HEAP_END = 16'(HEAP_WORDS);

  typedef enum logic [3:0] {
    S_IDLE, S_INIT, S_WRD, S_WHDR, S_NRD, S_NHDR, S_FIX,
    S_AWR1, S_AWR2, S_AWR3, S_RRD, S_RHDR, S_RWR, S_PRD, S_PDAT
  } st_e;

  st_e         state;
  heap_op_e    op_q;
  logic [15:0] arg_q, hid_q, need_q, ptr_q, span_q;
  logic        hf_q, merged_q;
  blk_hdr_t    upd_q;

  // Command screening and reference arithmetic.
  logic        reject;
  logic [15:0] need_w;
  heap_cmd_check #(.HEAP_WORDS(HEAP_WORDS), .MAX_REQ_WORDS(MAX_REQ_WORDS)) chk_i (
    .op(cmd_op), .arg(cmd_arg), .reject(reject), .need(need_w));

  logic [15:0] ram_rdata;
  blk_hdr_t    rd_hdr, upd_w;
  logic        upd_bad;
  assign rd_hdr = blk_hdr_t'(ram_rdata);

  heap_ref_update ref_i (
    .cur(rd_hdr), .raise(op_q == OP_ADDREF), .nxt(upd_w), .bad(upd_bad));

  // Headers composed for writing.
  blk_hdr_t init_hdr, alloc_hdr, rem_hdr, join_hdr;
  always_comb begin
    init_hdr  = '{is_free: 1'b1, has_handle: 1'b0, refs: 5'd0, words: HEAP_END[8:0]};
    alloc_hdr = '{is_free: 1'b0, has_handle: hf_q, refs: 5'd1, words: need_q[8:0]};
    rem_hdr   = '{is_free: 1'b1, has_handle: 1'b0, refs: 5'd0, words: 9'(span_q - need_q)};
    join_hdr  = '{is_free: 1'b1, has_handle: 1'b0, refs: 5'd0, words: span_q[8:0]};
  end

  // RAM port steering.
  logic          ram_we;
  logic [AW-1:0] ram_addr;
  logic [15:0]   ram_wdata;
  always_comb begin
    ram_we    = 1'b0;
    ram_addr  = AW'(ptr_q);
    ram_wdata = 16'd0;
    unique case (state)
      S_INIT: begin ram_we = 1'b1; ram_addr = '0; ram_wdata = init_hdr; end
      S_NRD:  ram_addr = AW'(ptr_q + span_q);
      S_FIX:  begin ram_we = 1'b1; ram_wdata = join_hdr; end
      S_AWR1: begin ram_we = 1'b1; ram_wdata = alloc_hdr; end
      S_AWR2: begin ram_we = 1'b1; ram_addr = AW'(ptr_q + need_q); ram_wdata = rem_hdr; end
      S_AWR3: begin ram_we = 1'b1; ram_addr = AW'(ptr_q + 16'd1); ram_wdata = hid_q; end
      S_RRD:  ram_addr = AW'(arg_q - 16'd1);
      S_RWR:  begin ram_we = 1'b1; ram_addr = AW'(arg_q - 16'd1); ram_wdata = upd_q; end
      S_PRD:  ram_addr = AW'(arg_q);
      default: ;
    endcase
  end

  heap_ram #(.DEPTH(HEAP_WORDS), .DW(16)) ram_i (
    .clk(clk), .we(ram_we), .addr(ram_addr), .wdata(ram_wdata), .rdata(ram_rdata));

  logic [15:0] cur_sz, joined;
  assign cur_sz = {7'd0, rd_hdr.words};
  assign joined = span_q + cur_sz;

  assign cmd_ready = (state == S_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      op_q      <= OP_INIT;
      arg_q     <= '0;
      hid_q     <= '0;
      need_q    <= '0;
      ptr_q     <= '0;
      span_q    <= '0;
      hf_q      <= 1'b0;
      merged_q  <= 1'b0;
      upd_q     <= '0;
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_addr  <= '0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= 1'b0;
      unique case (state)
        S_IDLE: if (cmd_valid) begin
          op_q   <= heap_op_e'(cmd_op);
          arg_q  <= cmd_arg;
          hf_q   <= cmd_handle;
          hid_q  <= cmd_handle_id;
          need_q <= need_w;
          if (reject) begin
            rsp_valid <= 1'b1; rsp_err <= 1'b1; rsp_addr <= '0; rsp_data <= '0;
          end else begin
            unique case (cmd_op)
              OP_INIT:            state <= S_INIT;
              OP_ALLOC:           begin ptr_q <= '0; merged_q <= 1'b0; state <= S_WRD; end
              OP_FREE, OP_ADDREF: state <= S_RRD;
              default:            state <= S_PRD;
            endcase
          end
        end
        S_INIT: begin
          rsp_valid <= 1'b1; rsp_err <= 1'b0; rsp_addr <= '0; rsp_data <= init_hdr;
          state <= S_IDLE;
        end
        S_WRD:  state <= S_WHDR;
        S_WHDR: begin
          if (cur_sz == 16'd0 || (!rd_hdr.is_free && ptr_q + cur_sz >= HEAP_END)) begin
            rsp_valid <= 1'b1; rsp_err <= 1'b1; rsp_addr <= '0; rsp_data <= '0;
            state <= S_IDLE;
          end else if (!rd_hdr.is_free) begin
            ptr_q <= ptr_q + cur_sz;
            state <= S_WRD;
          end else begin
            span_q   <= cur_sz;
            merged_q <= 1'b0;
            if (cur_sz >= need_q) state <= S_AWR1;
            else if (ptr_q + cur_sz < HEAP_END) state <= S_NRD;
            else begin
              rsp_valid <= 1'b1; rsp_err <= 1'b1; rsp_addr <= '0; rsp_data <= '0;
              state <= S_IDLE;
            end
          end
        end
        S_NRD:  state <= S_NHDR;
        S_NHDR: begin
          if (rd_hdr.is_free && cur_sz != 16'd0) begin
            span_q   <= joined;
            merged_q <= 1'b1;
            if (joined >= need_q) state <= S_AWR1;
            else if (ptr_q + joined < HEAP_END) state <= S_NRD;
            else state <= S_FIX;
          end else if (merged_q) begin
            state <= S_FIX;
          end else begin
            ptr_q <= ptr_q + span_q;
            state <= S_WRD;
          end
        end
        S_FIX: begin
          ptr_q    <= ptr_q + span_q;
          merged_q <= 1'b0;
          if (ptr_q + span_q >= HEAP_END) begin
            rsp_valid <= 1'b1; rsp_err <= 1'b1; rsp_addr <= '0; rsp_data <= '0;
            state <= S_IDLE;
          end else begin
            state <= S_WRD;
          end
        end
        S_AWR1, S_AWR2, S_AWR3: begin
          if (state == S_AWR1 && span_q > need_q) state <= S_AWR2;
          else if (state != S_AWR3 && hf_q) state <= S_AWR3;
          else begin
            rsp_valid <= 1'b1; rsp_err <= 1'b0;
            rsp_addr  <= ptr_q + 16'd1; rsp_data <= alloc_hdr;
            state <= S_IDLE;
          end
        end
        S_RRD:  state <= S_RHDR;
        S_RHDR: begin
          if (upd_bad) begin
            rsp_valid <= 1'b1; rsp_err <= 1'b1; rsp_addr <= arg_q; rsp_data <= ram_rdata;
            state <= S_IDLE;
          end else begin
            upd_q <= upd_w;
            state <= S_RWR;
          end
        end
        S_RWR: begin
          rsp_valid <= 1'b1; rsp_err <= 1'b0; rsp_addr <= arg_q; rsp_data <= upd_q;
          state <= S_IDLE;
        end
        S_PRD:  state <= S_PDAT;
        S_PDAT: begin
          rsp_valid <= 1'b1; rsp_err <= 1'b0; rsp_addr <= arg_q; rsp_data <= ram_rdata;
          state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // Guards on response contents and walk bounds.
  AST_ALLOC_ADDR_RANGE: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && op_q == OP_ALLOC && !rsp_err |-> rsp_addr != 16'd0 && rsp_addr < HEAP_END); // R2
  AST_ALLOC_FRESH_HDR: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && op_q == OP_ALLOC && !rsp_err |-> !rsp_data[15] && rsp_data[13:9] == 5'd1); // R2
  AST_ALLOC_LEN_LIMIT: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && op_q == OP_ALLOC && !rsp_err |-> rsp_data[8:0] >= 9'd2 && {7'd0, rsp_data[8:0]} <= 16'(MAX_REQ_WORDS + 1)); // R4
  AST_ALLOC_NULL_ON_ERR: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && op_q == OP_ALLOC && rsp_err |-> rsp_addr == 16'd0); // R5
  AST_WALK_IN_HEAP: assert property (@(posedge clk) disable iff (rst)
    state == S_WRD || state == S_NRD |-> ptr_q < HEAP_END); // R5
  AST_FREE_ONLY_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && op_q == OP_FREE && !rsp_err |-> rsp_data[15] == (rsp_data[13:9] == 5'd0)); // R6
  AST_ADDREF_ABOVE_ONE: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && op_q == OP_ADDREF && !rsp_err |-> rsp_data[13:9] >= 5'd2); // R7
  AST_RSP_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $past(state) != S_IDLE || $past(cmd_valid)); // R12

endmodule

// File: tb/heap_alloc_engine_tb.sv
`timescale 1ns/1ps
module heap_alloc_engine_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [2:0]  cmd_op = 3'd0;
  logic [15:0] cmd_arg = 16'd0;
  logic        cmd_handle = 1'b0;
  logic [15:0] cmd_handle_id = 16'd0;
  logic        rsp_valid, rsp_err;
  logic [15:0] rsp_addr, rsp_data;

  always #2.5 clk = ~clk;

  heap_alloc_engine #(.HEAP_WORDS(256), .MAX_REQ_WORDS(256)) dut_i (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_arg(cmd_arg), .cmd_handle(cmd_handle),
    .cmd_handle_id(cmd_handle_id), .rsp_valid(rsp_valid), .rsp_err(rsp_err),
    .rsp_addr(rsp_addr), .rsp_data(rsp_data));

  int total = 0;
  int bad   = 0;
  int cycles = 0;
  logic finished = 1'b0;

  logic        got, r_err;
  logic [15:0] r_addr, r_data;

  typedef struct packed {
    logic [2:0]  op;
    logic [15:0] arg;
    logic        hf;
    logic [15:0] hid;
    logic        e_err;
    logic        c_addr;
    logic [15:0] e_addr;
    logic [15:0] e_data;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 23;
  localparam vec_t VT [NV] = '{
    '{3'd0, 16'd0,   1'b0, 16'h0000, 1'b0, 1'b0, 16'd0,  16'h8100, 8'd1},  // R1 setup
    '{3'd4, 16'd0,   1'b0, 16'h0000, 1'b0, 1'b0, 16'd0,  16'h8100, 8'd1},  // R1 read back
    '{3'd1, 16'd3,   1'b0, 16'h0000, 1'b0, 1'b1, 16'd1,  16'h0204, 8'd2},  // R2 first alloc
    '{3'd4, 16'd4,   1'b0, 16'h0000, 1'b0, 1'b0, 16'd0,  16'h80FC, 8'd3},  // R3 remainder
    '{3'd1, 16'd10,  1'b1, 16'hBEEF, 1'b0, 1'b1, 16'd5,  16'h420B, 8'd8},  // R8 handle alloc
    '{3'd4, 16'd5,   1'b0, 16'h0000, 1'b0, 1'b0, 16'd0,  16'hBEEF, 8'd8},  // R8 handle word
    '{3'd4, 16'd15,  1'b0, 16'h0000, 1'b0, 1'b0, 16'd0,  16'h80F1, 8'd3},  // R3 remainder 2
    '{3'd1, 16'd0,   1'b0, 16'h0000, 1'b1, 1'b1, 16'd0,  16'h0000, 8'd4},  // R4 zero size
    '{3'd1, 16'd257, 1'b0, 16'h0000, 1'b1, 1'b1, 16'd0,  16'h0000, 8'd4},  // R4 oversize
    '{3'd1, 16'd256, 1'b0, 16'h0000, 1'b1, 1'b1, 16'd0,  16'h0000, 8'd5},  // R5 no fit
    '{3'd3, 16'd1,   1'b0, 16'h0000, 1'b0, 1'b0, 16'd0,  16'h0404, 8'd7},  // R7 add ref
    '{3'd2, 16'd1,   1'b0, 16'h0000, 1'b0, 1'b0, 16'd0,  16'h0204, 8'd6},  // R6 drop to 1
    '{3'd4, 16'd0,   1'b0, 16'h0000, 1'b0, 1'b0, 16'd0,  16'h0204, 8'd6},  // R6 still used
    '{3'd2, 16'd1,   1'b0, 16'h0000, 1'b0, 1'b0, 16'd0,  16'h8004, 8'd6},  // R6 now free
    '{3'd2, 16'd1,   1'b0, 16'h0000, 1'b1, 1'b0, 16'd0,  16'h8004, 8'd10}, // R10 free block
    '{3'd2, 16'd0,   1'b0, 16'h0000, 1'b1, 1'b0, 16'd0,  16'h0000, 8'd10}, // R10 address 0
    '{3'd3, 16'd300, 1'b0, 16'h0000, 1'b1, 1'b0, 16'd0,  16'h0000, 8'd10}, // R10 past end
    '{3'd4, 16'd300, 1'b0, 16'h0000, 1'b1, 1'b0, 16'd0,  16'h0000, 8'd11}, // R11 past end
    '{3'd2, 16'd5,   1'b0, 16'h0000, 1'b0, 1'b0, 16'd0,  16'h800B, 8'd6},  // R6 handle cleared
    '{3'd1, 16'd12,  1'b0, 16'h0000, 1'b0, 1'b1, 16'd1,  16'h020D, 8'd9},  // R9 joined fit
    '{3'd4, 16'd13,  1'b0, 16'h0000, 1'b0, 1'b0, 16'd0,  16'h8002, 8'd9},  // R9 split of join
    '{3'd1, 16'd1,   1'b0, 16'h0000, 1'b0, 1'b1, 16'd14, 16'h0202, 8'd2},  // R2 exact fit
    '{3'd4, 16'd15,  1'b0, 16'h0000, 1'b0, 1'b0, 16'd0,  16'h80F1, 8'd3}   // R3 untouched
  };

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_cmd(input logic [2:0] op, input logic [15:0] arg,
                         input logic hf, input logic [15:0] hid);
    int waitc;
    @(negedge clk);
    cmd_op = op; cmd_arg = arg; cmd_handle = hf; cmd_handle_id = hid;
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    waitc = 0;
    while (!rsp_valid && waitc < 2000) begin
      @(negedge clk);
      waitc++;
    end
    got = rsp_valid;
    r_err = rsp_err; r_addr = rsp_addr; r_data = rsp_data;
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000 && !finished) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=%0d expected=<150000", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    check("R12 ready in reset", {15'd0, cmd_ready}, 16'd1);
    rst = 1'b0;
    @(negedge clk);
    check("R12 ready after reset", {15'd0, cmd_ready}, 16'd1);
    check("R12 no rsp after reset", {15'd0, rsp_valid}, 16'd0);

    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = $sformatf("R%0d vec%0d", VT[i].req, i);
      run_cmd(VT[i].op, VT[i].arg, VT[i].hf, VT[i].hid);
      check({tag, " rsp"}, {15'd0, got}, 16'd1);
      check({tag, " err"}, {15'd0, r_err}, {15'd0, VT[i].e_err});
      if (VT[i].c_addr) check({tag, " addr"}, r_addr, VT[i].e_addr);
      check({tag, " data"}, r_data, VT[i].e_data);
    end

    // R7: raise count at address 14 from 1 to 31, then saturate.
    for (int k = 0; k < 30; k++) begin
      run_cmd(3'd3, 16'd14, 1'b0, 16'd0);
      if (k == 29) check("R7 count 31", r_data, 16'h3E02);
    end
    run_cmd(3'd3, 16'd14, 1'b0, 16'd0);
    check("R7 saturate err", {15'd0, r_err}, 16'd1);
    check("R7 saturate hdr", r_data, 16'h3E02);
    run_cmd(3'd4, 16'd13, 1'b0, 16'd0);
    check("R7 header kept", r_data, 16'h3E02);

    // R5: largest free block is 241 words, a 242-word block cannot fit.
    run_cmd(3'd1, 16'd241, 1'b0, 16'd0);
    check("R5 null addr", r_addr, 16'd0);
    check("R5 null err", {15'd0, r_err}, 16'd1);

    // R12: busy while a read is in flight, then a single pulse.
    @(negedge clk);
    cmd_op = 3'd4; cmd_arg = 16'd0; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    check("R12 busy", {15'd0, cmd_ready}, 16'd0);
    @(negedge clk);
    @(negedge clk);
    check("R12 pulse", {15'd0, rsp_valid}, 16'd1);
    @(negedge clk);
    check("R12 pulse ends", {15'd0, rsp_valid}, 16'd0);
    check("R12 idle again", {15'd0, cmd_ready}, 16'd1);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule